// File: doc/BRIEF.md
# Memory Bank Availability Tracker

This block keeps one availability line per memory bank on a split-transaction system bus. It watches every command placed on the address bus, a global hold line, and a per-bank completion pulse from the bank controllers. From these it drives each bank's availability line with fixed timing. The line drops after a command reaches the bank. It rises again only when two conditions hold: the bank controller has reported that it is nearly ready, and the coherence status for the last command has been posted, which the hold line signals by going low.

A read-lock command gives an atomic read-modify-write window. The bank stays unavailable until the same requester sends a write-unlock. The block records which requester took the lock. It screens every incoming command against the current availability of its bank. A command that is not allowed is ignored and reported with a one-cycle violation pulse.

Command opcodes on `cmd_op` are 0 = read, 1 = write, 2 = read-lock and 3 = write-unlock. Availability bit `b` of `bank_avl` belongs to the bank numbered `b`.

Top module: `bank_avail_tracker`

## Requirements
- R1: After reset every bit of `bank_avl` is 1, no bank is locked, and `violation` is 0.
- R2: An accepted command (any opcode 0..3) presented in cycle T to bank b leaves `bank_avl[b]` at 1 in cycle T+1 and drives it to 0 in cycle T+2.
- R3: For an unlocked busy bank whose hold status is already posted, `bank_avl[b]` is 0 in the cycle after that bank's `bank_done` pulse and rises to 1 two cycles after the pulse.
- R4: For an unlocked busy bank that has already seen its `bank_done` pulse, `bank_avl[b]` stays 0 until two cycles after `hold` goes from 1 to 0, and rises in that cycle.
- R5: A command that is not an allowed unlock is ignored and raises `violation` for exactly the next cycle when its bank's line is 0, or when the same bank was accepted in the previous cycle; an ignored command changes no bank's timing.
- R6: After a read-lock (opcode 2) to bank b, `bank_avl[b]` stays 0 whatever `bank_done` and `hold` do, until a write-unlock is accepted.
- R7: A write-unlock (opcode 3) to an unavailable bank is accepted only when that bank is locked and `cmd_src` equals the requester that locked it; otherwise it raises `violation` in the next cycle.
- R8: After an accepted write-unlock, the bank follows the normal release rules of R3 and R4 and its line rises again.
- R9: A command to one bank does not change the availability line of any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is on the address bus this cycle |
| cmd_bank | input | 4 | Target bank number |
| cmd_op | input | 2 | Opcode: 0 read, 1 write, 2 read-lock, 3 write-unlock |
| cmd_src | input | 4 | Requester identifier |
| hold | input | 1 | High while coherence status is pending; its fall means status is posted |
| bank_done | input | 16 | Per-bank completion pulse from the bank controllers |
| bank_avl | output | 16 | Per-bank availability line |
| violation | output | 1 | One-cycle pulse for a rejected command |

## Verification
The release timing is exercised in two orders, completion before the hold fall and hold fall before completion. This shows that the line waits for the later of the two events and then rises exactly two cycles after it. Locked banks receive a completion pulse and a hold fall, then an unlock from a foreign requester, and finally an unlock from the owner. This separates the lock gate from the owner match. Back-to-back commands to the same bank test the screening of a bank whose drop is still in flight. A command rejected in the middle of a release checks that rejected traffic leaves the timing untouched.

// File: rtl/bav_pkg.sv
package bav_pkg;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_RDLOCK   = 2'd2,
        OP_WRUNLOCK = 2'd3
    } bav_op_e;

endpackage

// File: rtl/bav_gate.sv
// Screens one incoming command against bank availability and lock ownership.
module bav_gate
    import bav_pkg::*;
#(
    parameter int NBANK = 16,
    parameter int SRCW  = 4,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic                   cmd_valid,
    input  logic [BW-1:0]          cmd_bank,
    input  bav_op_e                cmd_op,
    input  logic [SRCW-1:0]        cmd_src,
    input  logic [NBANK-1:0]       avl_vec,
    input  logic [NBANK-1:0]       lock_vec,
    input  logic [NBANK*SRCW-1:0]  owner_flat,
    input  logic                   pend_valid,
    input  logic [BW-1:0]          pend_bank,
    output logic                   accept,
    output logic                   reject
);

    logic            blocked;
    logic            unlock_ok;
    logic [SRCW-1:0] owner;

    always_comb begin
        owner     = owner_flat[32'(cmd_bank)*SRCW +: SRCW];
        blocked   = !avl_vec[cmd_bank] || (pend_valid && (pend_bank == cmd_bank));
        unlock_ok = (cmd_op == OP_WRUNLOCK) && lock_vec[cmd_bank] && (owner == cmd_src);
        accept    = cmd_valid && (!blocked || unlock_ok);
        reject    = cmd_valid && !accept;
    end

endmodule

// File: rtl/bav_slice.sv
// State of one bank: availability, release conditions and lock owner.
module bav_slice
    import bav_pkg::*;
#(
    parameter int SRCW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            apply,
    input  bav_op_e         op,
    input  logic [SRCW-1:0] src,
    input  logic            hold_fall,
    input  logic            done,
    output logic            avl,
    output logic            locked,
    output logic [SRCW-1:0] owner
);

    typedef struct packed {
        logic            avl;
        logic            busy;
        logic            posted;
        logic            seen;
        logic            locked;
        logic [SRCW-1:0] owner;
    } slice_st_t;

    slice_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply) begin
            st_d.avl    = 1'b0;
            st_d.busy   = 1'b1;
            st_d.posted = 1'b0;
            st_d.seen   = 1'b0;
            if (op == OP_RDLOCK) begin
                st_d.locked = 1'b1;
                st_d.owner  = src;
            end else if (op == OP_WRUNLOCK) begin
                st_d.locked = 1'b0;
            end
        end else if (st_q.busy) begin
            if (hold_fall) st_d.posted = 1'b1;
            if (done)      st_d.seen   = 1'b1;
            if (st_q.posted && st_q.seen && !st_q.locked) begin
                st_d.avl    = 1'b1;
                st_d.busy   = 1'b0;
                st_d.posted = 1'b0;
                st_d.seen   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.avl    <= 1'b1;
        end else begin
            st_q        <= st_d;
        end
    end

    assign avl    = st_q.avl;
    assign locked = st_q.locked;
    assign owner  = st_q.owner;

endmodule

// File: rtl/bank_avail_tracker.sv
module bank_avail_tracker
    import bav_pkg::*;
#(
    parameter int NBANK = 16,
    parameter int SRCW  = 4,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [BW-1:0]    cmd_bank,
    input  logic [1:0]       cmd_op,
    input  logic [SRCW-1:0]  cmd_src,
    input  logic             hold,
    input  logic [NBANK-1:0] bank_done,
    output logic [NBANK-1:0] bank_avl,
    output logic             violation
);

    typedef struct packed {
        logic            s1_valid;
        logic [BW-1:0]   s1_bank;
        bav_op_e         s1_op;
        logic [SRCW-1:0] s1_src;
        logic            hold_prev;
        logic            viol;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [NBANK-1:0]      lock_vec;
    logic [NBANK*SRCW-1:0] owner_flat;
    logic                  accept;
    logic                  reject;
    logic                  hold_fall;
    logic                  s1_valid;
    logic [BW-1:0]         s1_bank;

    bav_gate #(.NBANK(NBANK), .SRCW(SRCW)) gate_i (
        .cmd_valid (cmd_valid),
        .cmd_bank  (cmd_bank),
        .cmd_op    (bav_op_e'(cmd_op)),
        .cmd_src   (cmd_src),
        .avl_vec   (bank_avl),
        .lock_vec  (lock_vec),
        .owner_flat(owner_flat),
        .pend_valid(top_q.s1_valid),
        .pend_bank (top_q.s1_bank),
        .accept    (accept),
        .reject    (reject)
    );

    always_comb begin
        top_d           = top_q;
        top_d.s1_valid  = accept;
        top_d.s1_bank   = cmd_bank;
        top_d.s1_op     = bav_op_e'(cmd_op);
        top_d.s1_src    = cmd_src;
        top_d.hold_prev = hold;
        top_d.viol      = reject;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign hold_fall = top_q.hold_prev && !hold;
    assign violation = top_q.viol;
    assign s1_valid  = top_q.s1_valid;
    assign s1_bank   = top_q.s1_bank;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bav_slice #(.SRCW(SRCW)) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .apply    (top_q.s1_valid && (top_q.s1_bank == BW'(b))),
            .op       (top_q.s1_op),
            .src      (top_q.s1_src),
            .hold_fall(hold_fall),
            .done     (bank_done[b]),
            .avl      (bank_avl[b]),
            .locked   (lock_vec[b]),
            .owner    (owner_flat[b*SRCW +: SRCW])
        );
    end

endmodule

// File: rtl/bank_avail_tracker_chk.sv
module bank_avail_tracker_chk #(
    parameter int NBANK = 16,
    parameter int BW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [NBANK-1:0] bank_avl,
    input logic             violation,
    input logic             s1_valid,
    input logic [BW-1:0]    s1_bank,
    input logic [NBANK-1:0] lock_vec
);

    assert_drop_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> !bank_avl[$past(s1_bank)]);

    assert_fall_has_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~bank_avl & $past(bank_avl))) |-> $past(cmd_valid, 2));

    assert_violation_needs_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(cmd_valid));

    assert_locked_bank_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vec & bank_avl) == '0);

    assert_one_bank_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bank_avl & $past(bank_avl)) <= 1);

endmodule

bind bank_avail_tracker bank_avail_tracker_chk #(.NBANK(NBANK), .BW(BW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .bank_avl (bank_avl),
    .violation(violation),
    .s1_valid (s1_valid),
    .s1_bank  (s1_bank),
    .lock_vec (lock_vec)
);

// File: tb/bank_avail_tracker_tb_top.sv
module bank_avail_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, RL = 2'd2, WU = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_bank = '0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_src = '0;
    logic        hold = 1'b0;
    logic [15:0] bank_done = '0;
    logic [15:0] bank_avl;
    logic        violation;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        int    bank;   // -1 selects the violation output
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];

    bank_avail_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
        .cmd_op(cmd_op), .cmd_src(cmd_src), .hold(hold), .bank_done(bank_done),
        .bank_avl(bank_avl), .violation(violation)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input int bank, input logic val, input string tag);
        exp_t e;
        e.at = at; e.bank = bank; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare every expected item due in the current cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                if (sb[i].bank < 0) chk(violation, sb[i].val, sb[i].tag, "violation");
                else chk(bank_avl[sb[i].bank], sb[i].val, sb[i].tag,
                         $sformatf("bank_avl[%0d]", sb[i].bank));
                sb.delete(i);
            end else if (sb[i].at < cyc) begin
                nchk++; nfail++;
                $display("FAIL %s stale item: actual none expected check at cycle %0d", sb[i].tag, sb[i].at);
                sb.delete(i);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input int bank, input int src);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = 4'(bank); cmd_src = 4'(src);
        step(1);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_done(input int bank);
        bank_done[bank] = 1'b1;
        step(1);
        bank_done = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int c;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        for (int b = 0; b < 16; b++) chk(bank_avl[b], 1'b1, "R1", $sformatf("bank_avl[%0d]", b));
        chk(violation, 1'b0, "R1", "violation");

        // Completion first, then hold fall (R2, R4, R9)
        c = cyc; hold = 1'b1;
        push(c+1, 3, 1'b1, "R2"); push(c+2, 3, 1'b0, "R2"); push(c+2, 5, 1'b1, "R9");
        push(c+1, -1, 1'b0, "R2");
        send(RD, 3, 0);
        step(2);
        pulse_done(3);
        push(c+5, 3, 1'b0, "R4"); push(c+6, 3, 1'b0, "R4"); push(c+7, 3, 1'b1, "R4");
        step(1);
        hold = 1'b0;
        step(5);

        // Hold fall first, then completion; rejected command mid-release (R3, R5)
        c = cyc; hold = 1'b1;
        send(RD, 9, 1);
        step(2);
        hold = 1'b0;
        step(1);
        push(c+5, -1, 1'b1, "R5");
        send(RD, 9, 1);
        step(1);
        push(c+7, 9, 1'b0, "R3"); push(c+8, 9, 1'b1, "R3"); push(c+8, 9, 1'b1, "R5");
        pulse_done(9);
        step(5);

        // Lock, foreign unlock, owner unlock, release (R6, R7, R8)
        c = cyc; hold = 1'b1;
        push(c+2, 7, 1'b0, "R6");
        send(RL, 7, 2);
        step(2);
        hold = 1'b0;
        step(1);
        pulse_done(7);
        push(c+8, 7, 1'b0, "R6");
        step(4);
        push(c+10, -1, 1'b1, "R7"); push(c+10, 7, 1'b0, "R7");
        send(WU, 7, 5);
        step(1);
        push(c+12, -1, 1'b0, "R7");
        hold = 1'b1;
        send(WU, 7, 2);
        step(2);
        hold = 1'b0;
        step(1);
        push(c+16, 7, 1'b0, "R8"); push(c+17, 7, 1'b1, "R8");
        pulse_done(7);
        step(5);

        // Back-to-back commands, unlock of an unlocked busy bank, plain write
        c = cyc;
        push(c+2, 12, 1'b0, "R2");
        send(RD, 12, 0);
        push(c+2, -1, 1'b1, "R5");
        send(WR, 12, 0);
        push(c+3, -1, 1'b1, "R7");
        send(WU, 12, 0);
        push(c+4, -1, 1'b0, "R2"); push(c+5, 0, 1'b0, "R2"); push(c+5, 12, 1'b0, "R9");
        send(WR, 0, 3);
        step(5);

        if (sb.size() != 0) begin
            nchk++; nfail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        summary();
    end

endmodule